// File: doc/BRIEF.md
# I/O Cycle Routing Decoder

This block sits in a host bridge. For every processor I/O cycle it decides whether the cycle is claimed by the downstream PCI Express port or left on the default legacy path. It bases the decision on a small set of configuration registers:

- a 4 KB-granular I/O window given by a base nibble and a limit nibble;
- an I/O access enable;
- a legacy VGA forwarding enable;
- a flag that marks a monochrome adapter as present on the legacy side.

Requests arrive with a 16-bit address and a valid/ready handshake. The block accepts one request every cycle. One clock after acceptance it returns a registered, one-hot routing decision with a valid flag. Software programs and reads back the configuration through a simple select/write-enable port.

Top module: `io_route_dec`

## Requirements
- R1: After reset all configuration fields read as zero, `rsp_valid` is low, and every subsequent request routes to the default path (`rsp_route` = 2'b01) until the configuration is written.
- R2: With the I/O access enable set, an address is routed to PCI Express (`rsp_route` = 2'b10) when {base,000h} <= addr <= {limit,FFFh}. Both bounds are inclusive, and base and limit are compared as address bits 15:12.
- R3: When the limit nibble is below the base nibble, the window matches no address.
- R4: When the I/O access enable is clear, no request is routed to PCI Express, whatever the window or VGA settings.
- R5: With the I/O access enable and VGA enable both set, addresses 3B0h–3BBh and 3C0h–3DFh route to PCI Express even when outside the window. No aliasing on bits 15:10 applies.
- R6: With the monochrome flag set, ports 3B4h, 3B5h, 3B8h, 3B9h, 3BAh and 3BFh route to the default path, even when the VGA enable or the window would claim them.
- R7: `req_ready` is always high. `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high, so back-to-back requests give back-to-back responses.
- R8: `rsp_route` is always one-hot: bit 0 = default path, bit 1 = PCI Express.
- R9: Configuration register map:
  - select 0 holds {limit[7:4], base[3:0]};
  - select 1 holds {mono[2], vga_en[1], io_en[0]}, with the upper bits reading 0;
  - selects 2 and 3 read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wen | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for `cfg_sel` |
| req_valid | input | 1 | I/O request valid |
| req_ready | output | 1 | Request accepted (always high) |
| req_addr | input | 16 | I/O cycle address |
| rsp_valid | output | 1 | Routing decision valid |
| rsp_route | output | 2 | One-hot routing decision |

## Verification
The bench sweeps the window edges for several base/limit pairs, including a single 4 KB window, the top window at F000h–FFFFh, and an inverted pair. A design that dropped an inclusive bound, or forgot the implied FFFh, would misroute the first or last address of a window. A design that compared the inverted pair without care would claim addresses.

The full 380h–3FFh neighbourhood is swept under every combination of enable, VGA and monochrome flags. This exposes a wrong VGA range end, an override applied to the wrong ports, or a priority that lets VGA beat the monochrome override.

Back-to-back requests followed by an idle cycle catch a response that is late, early, or stuck valid.

// File: rtl/io_route_dec.sv
module io_route_dec #(
  parameter int AW = 16,
  parameter int NW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wen,
  input  logic [1:0]    cfg_sel,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  output logic          rsp_valid,
  output logic [1:0]    rsp_route
);
  localparam int SW = AW - NW;
  localparam logic [1:0] ROUTE_DEF  = 2'b01;
  localparam logic [1:0] ROUTE_PCIE = 2'b10;

  logic [NW-1:0] base_q, limit_q;
  logic          io_en_q, vga_en_q, mono_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      limit_q  <= '0;
      io_en_q  <= 1'b0;
      vga_en_q <= 1'b0;
      mono_q   <= 1'b0;
    end else if (cfg_wen) begin
      if (cfg_sel == 2'd0) begin
        base_q  <= cfg_wdata[NW-1:0];
        limit_q <= cfg_wdata[2*NW-1:NW];
      end else if (cfg_sel == 2'd1) begin
        io_en_q  <= cfg_wdata[0];
        vga_en_q <= cfg_wdata[1];
        mono_q   <= cfg_wdata[2];
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_sel == 2'd0) cfg_rdata[2*NW-1:0] = {limit_q, base_q};
    else if (cfg_sel == 2'd1) cfg_rdata[2:0] = {mono_q, vga_en_q, io_en_q};
  end

  logic [AW-1:0] win_lo, win_hi;
  logic          win_hit, vga_hit, mono_hit;
  logic [1:0]    route_d;

  assign win_lo  = {base_q, {SW{1'b0}}};
  assign win_hi  = {limit_q, {SW{1'b1}}};
  assign win_hit = (limit_q >= base_q) && (req_addr >= win_lo) && (req_addr <= win_hi);

  assign vga_hit = ((req_addr >= AW'(16'h3B0)) && (req_addr <= AW'(16'h3BB))) ||
                   ((req_addr >= AW'(16'h3C0)) && (req_addr <= AW'(16'h3DF)));

  always_comb begin
    case (req_addr)
      AW'(16'h3B4), AW'(16'h3B5), AW'(16'h3B8),
      AW'(16'h3B9), AW'(16'h3BA), AW'(16'h3BF): mono_hit = 1'b1;
      default:                                  mono_hit = 1'b0;
    endcase
  end

  always_comb begin
    if (mono_q && mono_hit)                  route_d = ROUTE_DEF;
    else if (!io_en_q)                       route_d = ROUTE_DEF;
    else if (win_hit || (vga_en_q && vga_hit)) route_d = ROUTE_PCIE;
    else                                     route_d = ROUTE_DEF;
  end

  assign req_ready = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_route <= ROUTE_DEF;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) rsp_route <= route_d;
    end
  end
endmodule

module io_route_dec_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [15:0] req_addr,
  input logic        io_en,
  input logic        mono,
  input logic        rsp_valid,
  input logic [1:0]  rsp_route
);
  AST_ROUTE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rsp_route) == 1); // R8
  AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready); // R7
  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R7
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R7
  AST_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !io_en) |=> !rsp_route[1]); // R4
  AST_MONO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mono && (req_addr == 16'h3B4 || req_addr == 16'h3BF)) |=> rsp_route == 2'b01); // R6
endmodule

bind io_route_dec io_route_dec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .io_en(io_en_q), .mono(mono_q),
  .rsp_valid(rsp_valid), .rsp_route(rsp_route)
);

// File: tb/test_io_route_dec.sv
`timescale 1ns/1ps
module test_io_route_dec;
  logic clk = 0, rst_n = 0;
  logic cfg_wen = 0;
  logic [1:0] cfg_sel = 0;
  logic [7:0] cfg_wdata = 0, cfg_rdata;
  logic req_valid = 0, req_ready;
  logic [15:0] req_addr = 0;
  logic rsp_valid;
  logic [1:0] rsp_route;
  int checks = 0, fails = 0;
  int s_base = 0, s_lim = 0, s_ioen = 0, s_vga = 0, s_mono = 0;

  always #10 clk = ~clk;

  io_route_dec i_io_route_dec (
    .clk(clk), .rst_n(rst_n), .cfg_wen(cfg_wen), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_route(rsp_route)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_route(int a);
    bit mono_port, vga_port, win;
    mono_port = (a == 'h3B4) || (a == 'h3B5) || (a == 'h3B8) ||
                (a == 'h3B9) || (a == 'h3BA) || (a == 'h3BF);
    vga_port  = (a >= 'h3B0 && a <= 'h3BB) || (a >= 'h3C0 && a <= 'h3DF);
    win = (s_lim >= s_base) && (a >= s_base * 4096) && (a <= s_lim * 4096 + 4095);
    if (s_mono && mono_port) return 1;
    if (!s_ioen) return 1;
    if (win || (s_vga && vga_port)) return 2;
    return 1;
  endfunction

  task automatic cfg_write(int sel, int data);
    req_valid = 0;
    cfg_sel = sel[1:0]; cfg_wdata = data[7:0]; cfg_wen = 1;
    @(negedge clk);
    cfg_wen = 0;
    if (sel == 0) begin s_base = data & 15; s_lim = (data >> 4) & 15; end
    if (sel == 1) begin s_ioen = data & 1; s_vga = (data >> 1) & 1; s_mono = (data >> 2) & 1; end
  endtask

  task automatic issue(int a, string req);
    req_addr = a[15:0]; req_valid = 1;
    @(negedge clk);
    chk({req, " valid"}, int'(rsp_valid), 1);
    chk({req, " route"}, int'(rsp_route), exp_route(a));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rsp_valid", int'(rsp_valid), 0);
    cfg_sel = 0; #1 chk("R1 sel0", int'(cfg_rdata), 0);
    cfg_sel = 1; #1 chk("R1 sel1", int'(cfg_rdata), 0);
    chk("R7 ready", int'(req_ready), 1);
    for (int a = 0; a < 65536; a += 251) issue(a, "R1");
    for (int a = 'h380; a < 'h400; a++) issue(a, "R1");
    req_valid = 0; @(negedge clk);
    chk("R7 idle", int'(rsp_valid), 0);

    // R9 map and ignored selects
    cfg_write(0, 'h52);
    cfg_write(1, 'hFF);
    cfg_write(2, 'hFF);
    cfg_write(3, 'hFF);
    cfg_sel = 0; #1 chk("R9 sel0", int'(cfg_rdata), 'h52);
    cfg_sel = 1; #1 chk("R9 sel1", int'(cfg_rdata), 'h07);
    cfg_sel = 2; #1 chk("R9 sel2", int'(cfg_rdata), 0);
    cfg_sel = 3; #1 chk("R9 sel3", int'(cfg_rdata), 0);

    // R2 / R3 window sweeps
    cfg_write(1, 'h01);
    foreach (int_pairs[i]) ;
    begin
      int pairs[5] = '{'h52, 'hF0, 'h77, 'h39, 'hFF};
      for (int p = 0; p < 5; p++) begin
        cfg_write(0, pairs[p]);
        for (int a = 0; a < 65536; a += 256) begin
          issue(a, (pairs[p] == 'h39) ? "R3" : "R2");
          issue(a + 255, (pairs[p] == 'h39) ? "R3" : "R2");
        end
        issue(s_base * 4096, "R2 low edge");
        issue(s_lim * 4096 + 4095, "R2 high edge");
        if (s_base > 0) issue(s_base * 4096 - 1, "R2 below");
        if (s_lim < 15) issue(s_lim * 4096 + 4096, "R2 above");
      end
    end

    // R4 gate clear with full window and VGA
    cfg_write(0, 'hF0);
    cfg_write(1, 'h02);
    for (int a = 0; a < 65536; a += 97) issue(a, "R4");

    // R5 / R6 legacy sweeps for all flag combinations
    cfg_write(0, 'h88);
    for (int f = 0; f < 8; f++) begin
      cfg_write(1, f);
      for (int a = 'h380; a < 'h400; a++) issue(a, f[2] ? "R6" : "R5");
    end
    // R6 mono beats the window too
    cfg_write(0, 'h00);
    cfg_write(1, 'h07);
    for (int a = 'h3B0; a < 'h3C0; a++) issue(a, "R6");
    req_valid = 0; @(negedge clk);
    chk("R7 idle end", int'(rsp_valid), 0);
    chk("R8 onehot", $countones(rsp_route), 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  int int_pairs[1];
endmodule